// File: doc/BRIEF.md
# Three-Channel Interval Timer

This block provides three independent 16-bit down-counters that software programs through a byte-wide register interface. There are four register addresses. Addresses 0, 1 and 2 are the data ports of channels 0, 1 and 2. Address 3 is the control port. A control word sets how a channel's count is written and read: low byte only, high byte only, or low byte followed by high byte. It also selects binary or BCD counting. The same port accepts two commands. One freezes a channel's count in a holding register. The other, a multi-channel read-back command, freezes counts and arms a status byte for several channels in one write.

Counting advances on a one-cycle `tick` strobe. When a running channel counts down to its terminal value, it reloads its programmed value and raises its output for one clock. Channel 2 counts only while `spk_ctl[0]` is high. The speaker output follows channel 2's pulse only while both `spk_ctl` bits are high. Read data is combinational, so it is valid in the same cycle as `rd`. Any side effect of a read takes place at that clock edge.

Top module: `interval_timer`

## Requirements
- R1: A control word at address 3 has its channel in bits 7:6 and its access code in bits 5:4 (1 = low byte only, 2 = high byte only, 3 = low then high). Bits 3:1 hold the mode and bit 0 selects BCD. A control word with a non-zero access code and channel 0..2 does four things: it stores bits 5:0 for that channel, clears the live count and the programmed value to zero, stops counting, and sets the update-pending flag. In the low-only and high-only codes, each data read returns the selected byte.
- R2: A control word with access code 0 copies the channel's live count into its holding register. A second such request while a value is already held is ignored, so the first value is kept until it has been read out.
- R3: A control word with bits 7:6 = 3 is a read-back command. It selects channel 0 with bit 1, channel 1 with bit 2 and channel 2 with bit 3. When bit 5 is 0 it freezes the counts of the selected channels. When bit 4 is 0 it arms a status read for the same channels.
- R4: While a status read is armed, a data read returns the status byte: bit 7 = 0, bit 6 = update pending, bits 5:0 = the stored control bits. That read clears the armed status and leaves the count byte sequence unchanged.
- R5: In the low-then-high code, reads and writes each keep their own byte toggle, and each toggle starts at the low byte. A held count is released after its high byte is read. In the single-byte codes, it is released after the one byte is read.
- R6: A written value becomes the count only when no high byte is still outstanding. At that point the update-pending flag clears and the countdown restarts from the new value. Writing the low byte of a low-then-high pair leaves the pending flag set.
- R7: A running binary channel counts down on each enabled tick. On a tick at a count of 1, it reloads its programmed value and drives its output high for exactly one clock. A programmed value of 0 acts as 65536, so a count of 0 becomes 0xFFFF on the next tick.
- R8: With the BCD bit set, the count runs as four decimal digits modulo 10000: 0x0000 steps to 0x9999 and 0x1000 steps to 0x0999.
- R9: Channel 2 counts only on ticks where `spk_ctl[0]` is 1. `spk_out` equals channel 2's output pulse while `spk_ctl` is 2'b11, and is 0 otherwise.
- R10: After reset, every channel is idle. Its stored control bits are 0, its count is 0, nothing is held or armed, outputs are low, and data reads return 0x00.
- R11: A read at address 3 returns 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle count enable strobe |
| spk_ctl | input | 2 | Bit 0 gates channel 2 counting; both bits set enable the speaker |
| addr | input | 2 | Register address: 0..2 channel data, 3 control |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the same cycle as rd |
| chan_out | output | 3 | One-clock terminal-count pulse per channel |
| spk_out | output | 1 | Channel 2 pulse gated by spk_ctl |

## Verification
A read toggle that has drifted shows at the very next data read as a swapped byte. A held count that was never released shows a frozen value on the following read, even after many ticks have passed. A stale update-pending flag appears in bit 6 of the next status byte. It also appears as a countdown that never restarts, which surfaces as a missing output pulse after exactly the programmed number of ticks. A wrong decimal borrow shows within one tick, as a non-decimal digit in the count.

// File: rtl/pit_pkg.sv
package pit_pkg;
   localparam int BYTE_W  = 8;
   localparam int CNT_W   = 16;
   localparam int DIGITS  = CNT_W / 4;

   typedef enum logic [1:0] {
      ACC_LATCH = 2'd0,
      ACC_LO    = 2'd1,
      ACC_HI    = 2'd2,
      ACC_LOHI  = 2'd3
   } acc_e;

   typedef struct packed {
      acc_e       acc;
      logic [2:0] mode;
      logic       bcd;
   } ctrl_t;

   // decimal decrement with a borrow chain across the nibbles
   function automatic logic [CNT_W-1:0] bcd_dec(input logic [CNT_W-1:0] v);
      logic [CNT_W-1:0] r;
      logic             borrow;
      r      = v;
      borrow = 1'b1;
      for (int d = 0; d < DIGITS; d++) begin
         if (borrow) begin
            if (v[d*4 +: 4] == 4'd0) begin
               r[d*4 +: 4] = 4'd9;
            end else begin
               r[d*4 +: 4] = v[d*4 +: 4] - 4'd1;
               borrow      = 1'b0;
            end
         end
      end
      return r;
   endfunction
endpackage

// File: rtl/pit_countdown.sv
module pit_countdown #(
   parameter bit BCD_EN = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clear,
   input  logic                    load,
   input  logic [pit_pkg::CNT_W-1:0] load_val,
   input  logic [pit_pkg::CNT_W-1:0] reload,
   input  logic                    en,
   input  logic                    bcd,
   output logic [pit_pkg::CNT_W-1:0] cnt_o,
   output logic                    run_o,
   output logic                    out_o
);
   localparam int W = pit_pkg::CNT_W;

   logic [W-1:0] cnt_q, dec;
   logic         run_q, out_q;

   generate
      if (BCD_EN) begin : g_bcd
         assign dec = bcd ? pit_pkg::bcd_dec(cnt_q) : cnt_q - 1'b1;
      end else begin : g_bin
         assign dec = cnt_q - 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         run_q <= 1'b0;
         out_q <= 1'b0;
      end else begin
         out_q <= 1'b0;
         if (clear) begin
            cnt_q <= '0;
            run_q <= 1'b0;
         end else if (load) begin
            cnt_q <= load_val;
            run_q <= 1'b1;
         end else if (en && run_q) begin
            if (cnt_q == W'(1)) begin
               cnt_q <= reload;
               out_q <= 1'b1;
            end else begin
               cnt_q <= dec;
            end
         end
      end
   end

   assign cnt_o = cnt_q;
   assign run_o = run_q;
   assign out_o = out_q;
endmodule

// File: rtl/pit_channel.sv
module pit_channel #(
   parameter bit BCD_EN = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      tick_en,
   input  logic                      ctl_wr,
   input  logic                      rb_latch,
   input  logic                      rb_status,
   input  logic                      data_wr,
   input  logic                      data_rd,
   input  logic [pit_pkg::BYTE_W-1:0] wdata,
   output logic [pit_pkg::BYTE_W-1:0] rdata,
   output logic                      out_pulse,
   output logic                      null_o,
   output logic                      run_o,
   output logic                      latched_o,
   output logic [pit_pkg::CNT_W-1:0]  latch_o
);
   import pit_pkg::*;

   ctrl_t            ctrl_q;
   logic [CNT_W-1:0] reload_q, reload_nxt, latch_q, cnt, val;
   logic             latched_q, stat_q, rtog_q, wtog_q, wtog_nxt, null_q;
   logic             do_load, ctl_prog, latch_req, rd_release, null_nxt;

   assign ctl_prog  = ctl_wr && (wdata[5:4] != 2'd0);
   assign latch_req = (ctl_wr && (wdata[5:4] == 2'd0)) || rb_latch;

   // write-side byte sequencing
   always_comb begin
      reload_nxt = reload_q;
      wtog_nxt   = wtog_q;
      do_load    = 1'b0;
      if (data_wr) begin
         unique case (ctrl_q.acc)
            ACC_LO: begin
               reload_nxt[7:0] = wdata;
               do_load         = 1'b1;
            end
            ACC_HI: begin
               reload_nxt[15:8] = wdata;
               do_load          = 1'b1;
            end
            ACC_LOHI: begin
               if (!wtog_q) begin
                  reload_nxt[7:0] = wdata;
                  wtog_nxt        = 1'b1;
               end else begin
                  reload_nxt[15:8] = wdata;
                  wtog_nxt         = 1'b0;
                  do_load          = 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

   always_comb begin
      null_nxt = null_q;
      if (do_load)
         null_nxt = 1'b0;
      else if (data_wr && ctrl_q.acc != ACC_LATCH)
         null_nxt = 1'b1;
   end

   // read-side byte selection
   assign val = latched_q ? latch_q : cnt;
   always_comb begin
      unique case (ctrl_q.acc)
         ACC_LO:   rdata = val[7:0];
         ACC_HI:   rdata = val[15:8];
         ACC_LOHI: rdata = rtog_q ? val[15:8] : val[7:0];
         default:  rdata = '0;
      endcase
      if (stat_q)
         rdata = {1'b0, null_q, ctrl_q};
   end

   assign rd_release = data_rd && !stat_q &&
                       ((ctrl_q.acc == ACC_LO) || (ctrl_q.acc == ACC_HI) ||
                        ((ctrl_q.acc == ACC_LOHI) && rtog_q));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q    <= '0;
         reload_q  <= '0;
         latch_q   <= '0;
         latched_q <= 1'b0;
         stat_q    <= 1'b0;
         rtog_q    <= 1'b0;
         wtog_q    <= 1'b0;
         null_q    <= 1'b0;
      end else if (ctl_prog) begin
         ctrl_q    <= ctrl_t'(wdata[5:0]);
         reload_q  <= '0;
         latched_q <= 1'b0;
         stat_q    <= 1'b0;
         rtog_q    <= 1'b0;
         wtog_q    <= 1'b0;
         null_q    <= 1'b1;
      end else begin
         reload_q <= reload_nxt;
         wtog_q   <= wtog_nxt;
         null_q   <= null_nxt;
         if (data_rd && stat_q)
            stat_q <= 1'b0;
         if (rb_status)
            stat_q <= 1'b1;
         if (data_rd && !stat_q && ctrl_q.acc == ACC_LOHI)
            rtog_q <= ~rtog_q;
         if (rd_release)
            latched_q <= 1'b0;
         if (latch_req && !latched_q) begin
            latch_q   <= cnt;
            latched_q <= 1'b1;
         end
      end
   end

   pit_countdown #(.BCD_EN(BCD_EN)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (ctl_prog),
      .load     (do_load),
      .load_val (reload_nxt),
      .reload   (reload_q),
      .en       (tick_en),
      .bcd      (ctrl_q.bcd),
      .cnt_o    (cnt),
      .run_o    (run_o),
      .out_o    (out_pulse)
   );

   assign null_o    = null_q;
   assign latched_o = latched_q;
   assign latch_o   = latch_q;
endmodule

// File: rtl/interval_timer.sv
module interval_timer #(
   parameter int NUM_CH  = 3,
   parameter int GATE_CH = 2,
   parameter bit BCD_EN  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [1:0]        spk_ctl,
   input  logic [1:0]        addr,
   input  logic              wr,
   input  logic              rd,
   input  logic [7:0]        wdata,
   output logic [7:0]        rdata,
   output logic [NUM_CH-1:0] chan_out,
   output logic              spk_out
);
   import pit_pkg::*;

   localparam logic [1:0] CTL_ADDR = 2'd3;
   localparam int         LW       = NUM_CH * CNT_W;

   generate
      if (NUM_CH < 1 || NUM_CH > 3) begin : g_bad_nch
         $error("NUM_CH must be 1 to 3");
      end
      if (CNT_W != 16 || BYTE_W != 8) begin : g_bad_w
         $error("byte interface needs 8-bit bytes and 16-bit counts");
      end
   endgenerate

   logic              ctl_sel, rb_cmd;
   logic [NUM_CH-1:0] null_v, run_v, latched_v;
   logic [LW-1:0]     latch_flat;
   logic [7:0]        ch_rd [NUM_CH];

   assign ctl_sel = wr && (addr == CTL_ADDR);
   assign rb_cmd  = ctl_sel && (wdata[7:6] == 2'd3);

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic en;
      if (i == GATE_CH) begin : g_gated
         assign en = tick && spk_ctl[0];
      end else begin : g_free
         assign en = tick;
      end

      pit_channel #(.BCD_EN(BCD_EN)) u_ch (
         .clk       (clk),
         .rst_n     (rst_n),
         .tick_en   (en),
         .ctl_wr    (ctl_sel && (wdata[7:6] == 2'(i))),
         .rb_latch  (rb_cmd && !wdata[5] && wdata[i+1]),
         .rb_status (rb_cmd && !wdata[4] && wdata[i+1]),
         .data_wr   (wr && (addr == 2'(i))),
         .data_rd   (rd && (addr == 2'(i))),
         .wdata     (wdata),
         .rdata     (ch_rd[i]),
         .out_pulse (chan_out[i]),
         .null_o    (null_v[i]),
         .run_o     (run_v[i]),
         .latched_o (latched_v[i]),
         .latch_o   (latch_flat[i*CNT_W +: CNT_W])
      );
   end

   always_comb begin
      rdata = 8'hFF;
      for (int i = 0; i < NUM_CH; i++)
         if (addr == 2'(i)) rdata = ch_rd[i];
   end

   generate
      if (GATE_CH < NUM_CH) begin : g_spk
         assign spk_out = chan_out[GATE_CH] && (spk_ctl == 2'b11);
      end else begin : g_nospk
         assign spk_out = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/pit_checker.sv
module pit_checker #(
   parameter int NUM_CH  = 3,
   parameter int GATE_CH = 2
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 tick,
   input logic                 gate,
   input logic [1:0]           addr,
   input logic                 wr,
   input logic                 rd,
   input logic [3:0]           wtop,
   input logic [NUM_CH-1:0]    chan_out,
   input logic [NUM_CH-1:0]    null_v,
   input logic [NUM_CH-1:0]    run_v,
   input logic [NUM_CH-1:0]    latched_v,
   input logic [NUM_CH*16-1:0] latch_flat
);
   for (genvar i = 0; i < NUM_CH; i++) begin : g_a
      // R1: programming a channel stops it and marks an update pending
      p_ctl_null_r1: assert property (@(posedge clk) disable iff (!rst_n)
         (wr && addr == 2'd3 && wtop[3:2] == 2'(i) && wtop[1:0] != 2'd0)
         |=> (null_v[i] && !run_v[i]));
      // R2: a held count is frozen while the bus is idle
      p_latch_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (latched_v[i] && !rd && !wr)
         |=> (latched_v[i] && $stable(latch_flat[i*16 +: 16])));
      // R6: clearing the pending flag coincides with a running countdown
      p_load_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(null_v[i]) |-> run_v[i]);
      // R7: an output pulse follows a tick
      p_out_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
         chan_out[i] |-> $past(tick));
   end

   generate
      if (GATE_CH < NUM_CH) begin : g_gate
         // R9: the gated channel pulses only after an enabled tick
         p_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
            chan_out[GATE_CH] |-> $past(gate));
      end
   endgenerate
endmodule

bind interval_timer pit_checker #(.NUM_CH(NUM_CH), .GATE_CH(GATE_CH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tick       (tick),
   .gate       (spk_ctl[0]),
   .addr       (addr),
   .wr         (wr),
   .rd         (rd),
   .wtop       (wdata[7:4]),
   .chan_out   (chan_out),
   .null_v     (null_v),
   .run_v      (run_v),
   .latched_v  (latched_v),
   .latch_flat (latch_flat)
);

// File: tb/sim_interval_timer.sv
`timescale 1ns/1ps
module sim_interval_timer;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic [1:0] spk_ctl = 2'b00;
   logic [1:0] addr = 2'd0;
   logic       wr = 1'b0;
   logic       rd = 1'b0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic [2:0] chan_out;
   logic       spk_out;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   interval_timer u0 (
      .clk(clk), .rst_n(rst_n), .tick(tick), .spk_ctl(spk_ctl),
      .addr(addr), .wr(wr), .rd(rd), .wdata(wdata),
      .rdata(rdata), .chan_out(chan_out), .spk_out(spk_out)
   );

   // vector: [23:20] requirement, [19] 1=read, [17:16] addr, [15:8] wdata, [7:0] expected
   localparam int NV = 28;
   localparam logic [23:0] VEC [NV] = '{
      24'hA_8_00_00,  // R10 reset read
      24'h1_3_34_00,  // R1 ch0 low/high, binary
      24'h1_0_34_00,
      24'h4_3_E2_00,  // R4 arm status ch0
      24'h6_8_00_74,  // R6 still pending after low byte
      24'h6_0_12_00,
      24'h5_8_00_34,  // R5 read low
      24'h5_8_00_12,  // R5 read high
      24'h4_3_E2_00,
      24'h4_8_00_34,  // R4 pending cleared
      24'h5_0_78_00,
      24'h5_8_00_34,  // R5 read toggle independent of write toggle
      24'h5_0_56_00,
      24'h5_8_00_56,
      24'h5_8_00_78,
      24'h1_3_54_00,  // R1 ch1 low only
      24'h1_1_AB_00,
      24'h1_9_00_AB,
      24'h1_9_00_AB,
      24'h1_3_A0_00,  // R1 ch2 high only
      24'h1_2_9C_00,
      24'h1_A_00_9C,
      24'h3_3_CC_00,  // R3 read-back ch1+ch2, count and status
      24'h3_9_00_14,
      24'h3_9_00_AB,
      24'h3_A_00_20,
      24'h3_A_00_9C,
      24'hB_B_00_FF   // R11 control address read
   };

   task automatic chk(input bit ok, input int req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL R%0d actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic bus_rd(input logic [1:0] a, input logic [7:0] exp, input int req);
      @(negedge clk);
      addr = a; rd = 1'b1;
      #1;
      chk(rdata === exp, req, rdata, exp);
      @(negedge clk);
      rd = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk); tick = 1'b1;
         @(negedge clk); tick = 1'b0;
      end
   endtask

   task automatic summary;
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   initial begin
      #1_000_000;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk(chan_out === 3'b000, 10, chan_out, 0);  // R10

      for (int v = 0; v < NV; v++) begin
         if (VEC[v][19]) bus_rd(VEC[v][17:16], VEC[v][7:0], int'(VEC[v][23:20]));
         else            bus_wr(VEC[v][17:16], VEC[v][15:8]);
      end

      // R2: a second latch is ignored until the first is read
      ticks(5);
      bus_wr(2'd3, 8'h40);
      ticks(3);
      bus_wr(2'd3, 8'h40);
      ticks(2);
      bus_rd(2'd1, 8'hA6, 2);
      bus_rd(2'd1, 8'hA1, 2);

      // R7: terminal count reload and one-clock pulse
      bus_wr(2'd3, 8'h14);
      bus_wr(2'd0, 8'h03);
      ticks(2);
      chk(chan_out[0] === 1'b0, 7, chan_out[0], 0);
      ticks(1);
      chk(chan_out[0] === 1'b1, 7, chan_out[0], 1);
      @(negedge clk);
      chk(chan_out[0] === 1'b0, 7, chan_out[0], 0);
      bus_rd(2'd0, 8'h03, 7);

      // R7: zero count wraps to 0xFFFF
      bus_wr(2'd3, 8'h30);
      bus_wr(2'd0, 8'h00);
      bus_wr(2'd0, 8'h00);
      ticks(1);
      bus_rd(2'd0, 8'hFF, 7);
      bus_rd(2'd0, 8'hFF, 7);

      // R8: decimal counting
      bus_wr(2'd3, 8'h31);
      bus_wr(2'd0, 8'h00);
      bus_wr(2'd0, 8'h00);
      ticks(1);
      bus_rd(2'd0, 8'h99, 8);
      bus_rd(2'd0, 8'h99, 8);
      ticks(1);
      bus_rd(2'd0, 8'h98, 8);
      bus_rd(2'd0, 8'h99, 8);
      bus_wr(2'd3, 8'h31);
      bus_wr(2'd0, 8'h00);
      bus_wr(2'd0, 8'h10);
      ticks(1);
      bus_rd(2'd0, 8'h99, 8);
      bus_rd(2'd0, 8'h09, 8);

      // R1: programming clears and stops the count
      bus_wr(2'd3, 8'h34);
      ticks(2);
      bus_rd(2'd0, 8'h00, 1);
      bus_rd(2'd0, 8'h00, 1);
      bus_wr(2'd3, 8'hE2);
      bus_rd(2'd0, 8'h74, 1);

      // R9: channel 2 gate and speaker enable
      bus_wr(2'd3, 8'h90);
      bus_wr(2'd2, 8'h02);
      ticks(3);
      bus_rd(2'd2, 8'h02, 9);
      spk_ctl = 2'b01;
      ticks(1);
      chk(chan_out[2] === 1'b0, 9, chan_out[2], 0);
      ticks(1);
      chk(chan_out[2] === 1'b1, 9, chan_out[2], 1);
      chk(spk_out === 1'b0, 9, spk_out, 0);
      spk_ctl = 2'b11;
      ticks(2);
      chk(chan_out[2] === 1'b1, 9, chan_out[2], 1);
      chk(spk_out === 1'b1, 9, spk_out, 1);

      // R10: reset mid-run returns everything to idle
      @(negedge clk); rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      chk(chan_out === 3'b000, 10, chan_out, 0);
      bus_rd(2'd0, 8'h00, 10);
      bus_wr(2'd3, 8'hE2);
      bus_rd(2'd0, 8'h00, 10);

      summary();
   end
endmodule